// File: doc/BRIEF.md
# Three-wire serial EEPROM master

This block drives a 16-bit-word serial EEPROM over a chip-select, clock, data-out and data-in wire set. It also drives a fourth pin that is held low while chip select is active and high otherwise. The internal side takes one request at a time: read a word, write a word, allow programming or forbid programming. It presents a word address and write data with the request and receives the read word, a one-cycle completion pulse and an error flag.

Right after reset, before it accepts any request, the block finds out whether the attached memory decodes 6 or 8 address bits. It sends a dummy read framed for the short address. It then looks at the data-in line. A memory that is still taking address bits leaves the line floating high, so the block finishes the longer frame with two zero bits. A short-address memory answers with its dummy zero. The result is held until the next reset. Every later command frame is 9 or 11 bits long, depending on this result.

After a write the block drops chip select and raises it again. It then watches data-in until the memory reports it is ready, and gives up with an error after a bounded number of serial half periods.

Top module: `uwire_eeprom_ctrl`

## Requirements
- R1: Out of reset, chip select is low, the auxiliary pin and the serial clock are high, data-out is low and busy is high, because address detection starts at once.
- R2: Detection sets `addr_wide` to 0 for a 6-bit-address memory and to 1 for an 8-bit one. Busy then falls without a `done` pulse.
- R3: Each frame starts with a start bit and is sent MSB first. The frame codes are 110 then the address for a read, 101 then the address then 16 data bits for a write, 10011 for enable and 10000 for disable. The enable and disable codes are padded with zeros, so a frame holds 9 or 11 command bits.
- R4: A read takes 16 bits from data-in, MSB first, after the command. It places them on `rd_data` in the same cycle that `done` pulses for one cycle.
- R5: After a write, the block re-selects the memory with the clock held low. It waits for data-in to go high before it pulses `done`.
- R6: If the write wait runs for POLL_LIMIT half periods, `err` is set and `done` pulses. `err` clears when the next request is accepted.
- R7: Chip select rises only when the clock and the auxiliary pin are both low. While chip select is high, the auxiliary pin stays low.
- R8: Chip select falls while the clock is low. The auxiliary pin rises together with the fall, and the clock returns high afterwards.
- R9: Data-out changes only while the clock is low or chip select is low. Every clock level lasts at least HALF_CYC system cycles, and HALF_CYC must be at least 4.
- R10: A request raised while busy is high is dropped and has no effect on the memory.
- R11: In 6-bit mode only the low 6 bits of `cmd_addr` are sent. In 8-bit mode all 8 bits are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Request strobe, taken when busy is low |
| cmd_op | input | 2 | 0 read, 1 write, 2 allow programming, 3 forbid programming |
| cmd_addr | input | 8 | Word address |
| cmd_wdata | input | 16 | Word to write |
| rd_data | output | 16 | Last word read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Detection or a request in progress |
| err | output | 1 | Write-ready wait timed out |
| addr_wide | output | 1 | 1 when the memory takes 8 address bits |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_pre | output | 1 | Auxiliary pin, low while selected |
| ee_do | input | 1 | Serial data from the memory |

## Verification
The bench builds two copies. The first uses HALF_CYC=4 and POLL_LIMIT=64 and faces a 6-bit memory model. With that short poll limit, a model that stays busy for 2000 cycles hits the timeout, and a model that stays busy for 100 cycles ends the wait normally. The second uses HALF_CYC=5 and POLL_LIMIT=64 with an 8-bit model. That copy covers the two extra detection bits, the 11-bit frames and the full address field, all at a clock divider that is not a power of two.

// File: rtl/uwe_pkg.sv
package uwe_pkg;
   localparam int WORD_W     = 16;
   localparam int OPC_BITS   = 3;
   localparam int AW_NARROW  = 6;
   localparam int AW_WIDE    = 8;
   localparam int CMD_NARROW = OPC_BITS + AW_NARROW;
   localparam int CMD_WIDE   = OPC_BITS + AW_WIDE;
   localparam int FRAME_W    = 2 * WORD_W;

   localparam logic [WORD_W-1:0] OPC_RD  = 16'hC000;
   localparam logic [WORD_W-1:0] OPC_WR  = 16'hA000;
   localparam logic [WORD_W-1:0] OPC_EN  = 16'h9800;
   localparam logic [WORD_W-1:0] OPC_DIS = 16'h8000;

   typedef enum logic [1:0] {
      OP_READ = 2'd0,
      OP_WRITE = 2'd1,
      OP_WEN = 2'd2,
      OP_WDS = 2'd3
   } uwe_op_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_CS0, ST_CS1, ST_CS2, ST_DROP,
      ST_RAISE, ST_HOLD, ST_E1, ST_E2, ST_POLL
   } uwe_state_e;
endpackage

// File: rtl/uwe_tick.sv
module uwe_tick #(
   parameter int HALF_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

   generate
      if (HALF_CYC < 4) begin : g_bad_half
         $error("HALF_CYC must be at least 4");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign tick = en && (cnt == CW'(HALF_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!en || tick) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/uwe_frame.sv
module uwe_frame
   import uwe_pkg::*;
(
   input  uwe_op_e              op,
   input  logic [AW_WIDE-1:0]   addr,
   input  logic [WORD_W-1:0]    wdata,
   input  logic                 wide,
   output logic [FRAME_W-1:0]   frame,
   output logic [5:0]           nout,
   output logic [4:0]           nin
);
   localparam int SH_NARROW = WORD_W - CMD_NARROW;
   localparam int SH_WIDE   = WORD_W - CMD_WIDE;

   logic [WORD_W-1:0] base, afield, cmd16;
   logic [5:0]        ncmd;

   always_comb begin
      ncmd   = wide ? 6'(CMD_WIDE) : 6'(CMD_NARROW);
      afield = wide ? (WORD_W'(addr) << SH_WIDE)
                    : (WORD_W'(addr[AW_NARROW-1:0]) << SH_NARROW);
      unique case (op)
         OP_READ:  base = OPC_RD;
         OP_WRITE: base = OPC_WR;
         OP_WEN:   base = OPC_EN;
         default:  base = OPC_DIS;
      endcase
      cmd16 = base | (((op == OP_READ) || (op == OP_WRITE)) ? afield : '0);
      frame = {cmd16, {WORD_W{1'b0}}};
      if (op == OP_WRITE)
         frame = frame | (FRAME_W'(wdata) << (wide ? SH_WIDE : SH_NARROW));
      nout = ncmd + ((op == OP_WRITE) ? 6'(WORD_W) : 6'd0);
      nin  = (op == OP_READ) ? 5'(WORD_W) : 5'd0;
   end
endmodule

// File: rtl/uwire_eeprom_ctrl.sv
module uwire_eeprom_ctrl
   import uwe_pkg::*;
#(
   parameter int HALF_CYC   = 4,
   parameter int POLL_LIMIT = 4096
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_valid,
   input  logic [1:0]  cmd_op,
   input  logic [7:0]  cmd_addr,
   input  logic [15:0] cmd_wdata,
   output logic [15:0] rd_data,
   output logic        done,
   output logic        busy,
   output logic        err,
   output logic        addr_wide,
   output logic        ee_cs,
   output logic        ee_sk,
   output logic        ee_di,
   output logic        ee_pre,
   input  logic        ee_do
);
   localparam int PCW = $clog2(POLL_LIMIT + 1);

   generate
      if (POLL_LIMIT < 1) begin : g_bad_poll
         $error("POLL_LIMIT must be positive");
      end
   endgenerate

   uwe_state_e         st;
   logic               tick;
   logic [FRAME_W-1:0] sh, f_frame;
   logic [5:0]         out_left, f_nout, nx_out;
   logic [4:0]         in_left, f_nin, nx_in;
   logic [WORD_W-1:0]  rx;
   logic               detecting, post_write, polling, is_read, user;
   logic [PCW-1:0]     poll_cnt;
   uwe_op_e            op_in;

   assign op_in = uwe_op_e'(cmd_op);
   assign busy  = (st != ST_IDLE);

   uwe_tick #(.HALF_CYC(HALF_CYC)) u_tick (
      .clk (clk), .rst_n (rst_n), .en (busy), .tick (tick)
   );

   uwe_frame u_frame (
      .op (op_in), .addr (cmd_addr), .wdata (cmd_wdata), .wide (addr_wide),
      .frame (f_frame), .nout (f_nout), .nin (f_nin)
   );

   always_comb begin
      nx_out = out_left;
      nx_in  = in_left;
      if (out_left != 6'd0) begin
         nx_out = out_left - 6'd1;
         if (detecting && (out_left == 6'd1) && ee_do) nx_out = 6'd2;
      end else if (in_left != 5'd0) begin
         nx_in = in_left - 5'd1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_CS0;
         sh         <= {OPC_RD, {WORD_W{1'b0}}};
         out_left   <= 6'(CMD_NARROW);
         in_left    <= 5'(WORD_W);
         rx         <= '0;
         rd_data    <= '0;
         detecting  <= 1'b1;
         addr_wide  <= 1'b0;
         post_write <= 1'b0;
         polling    <= 1'b0;
         is_read    <= 1'b0;
         user       <= 1'b0;
         poll_cnt   <= '0;
         err        <= 1'b0;
         done       <= 1'b0;
         ee_cs      <= 1'b0;
         ee_sk      <= 1'b1;
         ee_di      <= 1'b0;
         ee_pre     <= 1'b1;
      end else begin
         done <= 1'b0;
         if (st == ST_IDLE) begin
            if (cmd_valid) begin
               sh         <= f_frame;
               out_left   <= f_nout;
               in_left    <= f_nin;
               post_write <= (op_in == OP_WRITE);
               is_read    <= (op_in == OP_READ);
               user       <= 1'b1;
               err        <= 1'b0;
               st         <= ST_CS0;
            end
         end else if (tick) begin
            unique case (st)
               ST_CS0: begin
                  ee_di  <= 1'b0;
                  ee_sk  <= 1'b0;
                  ee_pre <= 1'b0;
                  st     <= ST_CS1;
               end
               ST_CS1: begin
                  ee_cs    <= 1'b1;
                  poll_cnt <= '0;
                  st       <= polling ? ST_POLL : ST_CS2;
               end
               ST_CS2: begin
                  ee_sk <= 1'b1;
                  st    <= ST_DROP;
               end
               ST_DROP: begin
                  ee_sk <= 1'b0;
                  ee_di <= sh[FRAME_W-1];
                  st    <= ST_RAISE;
               end
               ST_RAISE: begin
                  ee_sk <= 1'b1;
                  st    <= ST_HOLD;
               end
               ST_HOLD: begin
                  ee_sk    <= 1'b0;
                  out_left <= nx_out;
                  in_left  <= nx_in;
                  if (out_left != 6'd0) begin
                     sh    <= sh << 1;
                     ee_di <= sh[FRAME_W-2];
                     if (detecting && (out_left == 6'd1)) begin
                        addr_wide <= ee_do;
                        detecting <= 1'b0;
                     end
                  end else begin
                     ee_di <= 1'b0;
                     if (in_left != 5'd0) rx <= {rx[WORD_W-2:0], ee_do};
                  end
                  st <= ((nx_out != 6'd0) || (nx_in != 5'd0)) ? ST_RAISE : ST_E1;
               end
               ST_POLL: begin
                  if (ee_do) begin
                     st <= ST_E1;
                  end else if (poll_cnt == PCW'(POLL_LIMIT - 1)) begin
                     err <= 1'b1;
                     st  <= ST_E1;
                  end else begin
                     poll_cnt <= poll_cnt + 1'b1;
                  end
               end
               ST_E1: begin
                  ee_cs  <= 1'b0;
                  ee_pre <= 1'b1;
                  st     <= ST_E2;
               end
               ST_E2: begin
                  ee_sk <= 1'b1;
                  if (post_write) begin
                     post_write <= 1'b0;
                     polling    <= 1'b1;
                     st         <= ST_CS0;
                  end else begin
                     polling <= 1'b0;
                     done    <= user;
                     if (is_read) rd_data <= rx;
                     st <= ST_IDLE;
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/uwe_chk.sv
module uwe_chk (
   input logic clk,
   input logic rst_n,
   input logic ee_cs,
   input logic ee_sk,
   input logic ee_di,
   input logic ee_pre,
   input logic done,
   input logic busy
);
   // R7: the auxiliary pin is low whenever the memory is selected
   p_pre_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ee_cs |-> !ee_pre);
   // R7: selection begins with clock and auxiliary pin low
   p_cs_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_cs) |-> (!ee_sk && !ee_pre));
   // R8: deselection happens with the clock low
   p_cs_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ee_cs) |-> (!ee_sk && ee_pre));
   // R9: data held while the clock is high and selected
   p_di_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_cs && ee_sk && $past(ee_sk)) |-> $stable(ee_di));
   // R9: no clock level shorter than two system cycles
   p_sk_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ee_sk) |=> $stable(ee_sk));
   // R4: completion is a single-cycle pulse
   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R4: completion coincides with the idle state
   p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind uwire_eeprom_ctrl uwe_chk u_chk (
   .clk (clk), .rst_n (rst_n), .ee_cs (ee_cs), .ee_sk (ee_sk),
   .ee_di (ee_di), .ee_pre (ee_pre), .done (done), .busy (busy)
);

// File: tb/uwire_eeprom_ctrl_tb.sv
module uwe_mem_model #(
   parameter int AW = 6
) (
   input  logic clk,
   input  logic cs,
   input  logic sk,
   input  logic di,
   input  int   busy_len,
   output logic do_o,
   output logic wen_o,
   output int   frame_o,
   output logic busy_o
);
   localparam int C = 3 + AW;
   logic [15:0] mem [2**AW];
   int          nb = 0;
   int          bc = 0;
   int          fr = 0;
   logic [10:0] sr = '0;
   logic [2:0]  op = '0;
   logic [AW-1:0] ad = '0;
   logic [15:0] wb = '0;
   logic [15:0] rw = '0;
   logic        pend = 1'b0;
   logic        we = 1'b0;
   logic        cs_q = 1'b0;
   logic        sk_q = 1'b1;

   initial begin
      for (int i = 0; i < 2**AW; i++) mem[i] = {8'(i) ^ 8'h5A, ~8'(i)};
   end

   assign wen_o   = we;
   assign frame_o = fr;
   assign busy_o  = (bc > 0);
   assign do_o = (bc > 0) ? 1'b0 :
                 (nb < C) ? 1'b1 :
                 (nb == C) ? 1'b0 :
                 ((op == 3'b110) && (nb <= C + 16)) ? rw[C + 16 - nb] : 1'b0;

   always @(posedge clk) begin : mdl
      logic [10:0] full;
      cs_q <= cs;
      sk_q <= sk;
      if (bc > 0) bc <= bc - 1;
      if (cs_q && !cs) begin
         if (nb != 0) fr <= nb;
         nb <= 0;
         if (pend) begin
            pend <= 1'b0;
            bc   <= busy_len;
         end
      end else if (cs && sk && !sk_q && (nb != 0 || di)) begin
         nb <= nb + 1;
         if (nb < C) begin
            full = {sr[9:0], di};
            sr <= full;
            if (nb == C - 1) begin
               op <= full[C-1 -: 3];
               ad <= full[AW-1:0];
               rw <= mem[full[AW-1:0]];
               if (full[C-1 -: 3] == 3'b100 && full[AW-1 -: 2] == 2'b11) we <= 1'b1;
               if (full[C-1 -: 3] == 3'b100 && full[AW-1 -: 2] == 2'b00) we <= 1'b0;
            end
         end else if (op == 3'b101 && nb < C + 16) begin
            wb <= {wb[14:0], di};
            if (nb == C + 15 && we) begin
               mem[ad] <= {wb[14:0], di};
               pend    <= 1'b1;
            end
         end
      end
   end
endmodule

module uwire_eeprom_ctrl_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int nchk = 0;
   int nerr = 0;
   bit fin = 1'b0;

   logic        c0_valid = 1'b0, c1_valid = 1'b0;
   logic [1:0]  c0_op = '0, c1_op = '0;
   logic [7:0]  c0_addr = '0, c1_addr = '0;
   logic [15:0] c0_wdata = '0, c1_wdata = '0;
   logic [15:0] c0_rd, c1_rd;
   logic        c0_done, c1_done, c0_busy, c1_busy, c0_err, c1_err, c0_wide, c1_wide;
   logic        c0_cs, c0_sk, c0_di, c0_pre, c0_do;
   logic        c1_cs, c1_sk, c1_di, c1_pre, c1_do;
   logic        m0_wen, m1_wen, m0_busy, m1_busy;
   int          m0_frame, m1_frame;
   int          m0_blen = 100;
   int          m1_blen = 100;

   uwire_eeprom_ctrl #(.HALF_CYC(4), .POLL_LIMIT(64)) u_dut (
      .clk (clk), .rst_n (rst_n), .cmd_valid (c0_valid), .cmd_op (c0_op),
      .cmd_addr (c0_addr), .cmd_wdata (c0_wdata), .rd_data (c0_rd),
      .done (c0_done), .busy (c0_busy), .err (c0_err), .addr_wide (c0_wide),
      .ee_cs (c0_cs), .ee_sk (c0_sk), .ee_di (c0_di), .ee_pre (c0_pre), .ee_do (c0_do)
   );
   uwe_mem_model #(.AW(6)) u_m0 (
      .clk (clk), .cs (c0_cs), .sk (c0_sk), .di (c0_di), .busy_len (m0_blen),
      .do_o (c0_do), .wen_o (m0_wen), .frame_o (m0_frame), .busy_o (m0_busy)
   );

   uwire_eeprom_ctrl #(.HALF_CYC(5), .POLL_LIMIT(64)) u_dut_w (
      .clk (clk), .rst_n (rst_n), .cmd_valid (c1_valid), .cmd_op (c1_op),
      .cmd_addr (c1_addr), .cmd_wdata (c1_wdata), .rd_data (c1_rd),
      .done (c1_done), .busy (c1_busy), .err (c1_err), .addr_wide (c1_wide),
      .ee_cs (c1_cs), .ee_sk (c1_sk), .ee_di (c1_di), .ee_pre (c1_pre), .ee_do (c1_do)
   );
   uwe_mem_model #(.AW(8)) u_m1 (
      .clk (clk), .cs (c1_cs), .sk (c1_sk), .di (c1_di), .busy_len (m1_blen),
      .do_o (c1_do), .wen_o (m1_wen), .frame_o (m1_frame), .busy_o (m1_busy)
   );

   // pin-sequence monitors on u_dut (R7, R8, R9)
   int   v_start = 0, v_end = 0, v_half = 0, n_cs = 0, n_done0 = 0;
   int   run = 100;
   logic cs_p = 1'b0, sk_p = 1'b1;
   always @(posedge clk) begin
      if (rst_n) begin
         if (c0_cs && !cs_p) begin
            n_cs++;
            if (c0_sk || c0_pre) v_start++;
         end
         if (!c0_cs && cs_p && c0_sk) v_end++;
         if (c0_sk != sk_p) begin
            if (run < 4) v_half++;
            run = 1;
         end else begin
            run++;
         end
         if (c0_done) n_done0++;
      end
      cs_p = c0_cs;
      sk_p = c0_sk;
   end

   function automatic logic [15:0] init_val(input int i);
      return {8'(i) ^ 8'h5A, ~8'(i)};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic issue(input bit w, input logic [1:0] op, input logic [7:0] a,
                        input logic [15:0] d);
      @(negedge clk);
      while (w ? c1_busy : c0_busy) @(negedge clk);
      if (w) begin c1_valid = 1'b1; c1_op = op; c1_addr = a; c1_wdata = d; end
      else   begin c0_valid = 1'b1; c0_op = op; c0_addr = a; c0_wdata = d; end
      @(negedge clk);
      c0_valid = 1'b0;
      c1_valid = 1'b0;
      for (int k = 0; k < 20000; k++) begin
         if (w ? c1_done : c0_done) break;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      check(c0_cs == 1'b0, "R1 cs", 32'(c0_cs), 0);
      check(c0_pre == 1'b1, "R1 pre", 32'(c0_pre), 1);
      check(c0_sk == 1'b1, "R1 sk", 32'(c0_sk), 1);
      check(c0_di == 1'b0, "R1 di", 32'(c0_di), 0);
      check(c0_busy && c1_busy, "R1 busy", 32'({c0_busy, c1_busy}), 3);
   endtask

   task automatic t_ignore_and_detect;
      // R10: request during detection is dropped
      repeat (3) @(negedge clk);
      c0_valid = 1'b1; c0_op = 2'd2;
      @(negedge clk);
      c0_valid = 1'b0;
      while (c0_busy || c1_busy) @(negedge clk);
      repeat (4) @(negedge clk);
      check(m0_wen == 1'b0, "R10 enable while busy", 32'(m0_wen), 0);
      check(c0_wide == 1'b0, "R2 narrow", 32'(c0_wide), 0);
      check(c1_wide == 1'b1, "R2 wide", 32'(c1_wide), 1);
      check(n_done0 == 0, "R2 no done", 32'(n_done0), 0);
   endtask

   task automatic t_protect;
      issue(1'b0, 2'd1, 8'h05, 16'h1111);
      issue(1'b0, 2'd0, 8'h05, 16'h0);
      check(c0_rd == init_val(5), "R3 protected write", 32'(c0_rd), 32'(init_val(5)));
   endtask

   task automatic t_narrow;
      issue(1'b0, 2'd2, 8'h00, 16'h0);
      repeat (4) @(negedge clk);
      check(m0_wen == 1'b1, "R3 enable code", 32'(m0_wen), 1);
      check(m0_frame == 9, "R3 enable length", 32'(m0_frame), 9);
      issue(1'b0, 2'd1, 8'h45, 16'h1234);
      check(m0_frame == 25, "R3 write length", 32'(m0_frame), 25);
      check(c0_err == 1'b0, "R5 no err", 32'(c0_err), 0);
      issue(1'b0, 2'd0, 8'h05, 16'h0);
      check(c0_rd == 16'h1234, "R11 narrow addr", 32'(c0_rd), 32'h1234);
      check(c0_done == 1'b1, "R4 done with data", 32'(c0_done), 1);
   endtask

   task automatic t_wide;
      issue(1'b1, 2'd2, 8'h00, 16'h0);
      repeat (4) @(negedge clk);
      check(m1_frame == 11, "R3 wide enable length", 32'(m1_frame), 11);
      issue(1'b1, 2'd1, 8'hC3, 16'hBEEF);
      check(m1_frame == 27, "R3 wide write length", 32'(m1_frame), 27);
      issue(1'b1, 2'd0, 8'hC3, 16'h0);
      check(c1_rd == 16'hBEEF, "R4 wide read", 32'(c1_rd), 32'hBEEF);
      issue(1'b1, 2'd0, 8'h43, 16'h0);
      check(c1_rd == init_val(8'h43), "R11 wide addr", 32'(c1_rd), 32'(init_val(8'h43)));
   endtask

   task automatic t_disable;
      issue(1'b0, 2'd3, 8'h00, 16'h0);
      repeat (4) @(negedge clk);
      check(m0_wen == 1'b0, "R3 disable code", 32'(m0_wen), 0);
      issue(1'b0, 2'd1, 8'h05, 16'hAAAA);
      issue(1'b0, 2'd0, 8'h05, 16'h0);
      check(c0_rd == 16'h1234, "R3 write after disable", 32'(c0_rd), 32'h1234);
   endtask

   task automatic t_poll;
      m0_blen = 100;
      issue(1'b0, 2'd2, 8'h00, 16'h0);
      issue(1'b0, 2'd1, 8'h06, 16'h0F0F);
      check(m0_busy == 1'b0, "R5 waited for ready", 32'(m0_busy), 0);
      check(c0_err == 1'b0, "R5 err clear", 32'(c0_err), 0);
      issue(1'b0, 2'd0, 8'h06, 16'h0);
      check(c0_rd == 16'h0F0F, "R4 read after poll", 32'(c0_rd), 32'h0F0F);
   endtask

   task automatic t_timeout;
      m0_blen = 2000;
      issue(1'b0, 2'd1, 8'h07, 16'h7777);
      check(c0_err == 1'b1, "R6 timeout err", 32'(c0_err), 1);
      check(m0_busy == 1'b1, "R6 gave up early", 32'(m0_busy), 1);
      repeat (2100) @(negedge clk);
      m0_blen = 100;
      issue(1'b0, 2'd0, 8'h07, 16'h0);
      check(c0_err == 1'b0, "R6 err cleared", 32'(c0_err), 0);
      check(c0_rd == 16'h7777, "R6 data stored", 32'(c0_rd), 32'h7777);
   endtask

   task automatic t_pins;
      check(n_cs > 5, "R7 selections seen", 32'(n_cs), 6);
      check(v_start == 0, "R7 select order", 32'(v_start), 0);
      check(v_end == 0, "R8 deselect order", 32'(v_end), 0);
      check(v_half == 0, "R9 half period", 32'(v_half), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_ignore_and_detect();
      t_protect();
      t_narrow();
      t_wide();
      t_disable();
      t_poll();
      t_timeout();
      t_pins();
      fin = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog actual hung expected finished");
         $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end
endmodule